// File: doc/BRIEF.md
# Strobe Watchdog with Selectable Timeout

This block supervises a processor by watching a strobe line that the firmware must keep exercising. Once the system leaves reset, a countdown runs on a 1 ms tick enable. Each falling edge of the strobe reloads it. If the countdown reaches its end, the block raises a one-cycle timeout request. A separate reset generator uses that request to stretch a system reset of at least 250 ms.

A two-bit select input picks one of three periods: 150, 600 or 1200 ticks. The period is captured whenever the counter loads, so a change on the select input waits for the next reload. The watchdog has no disable. While the system reset is active, the counter is held idle and strobe activity is ignored. Each release of reset arms it again from the full period, so firmware that never strobes keeps causing resets.

The strobe passes through a synchroniser before edge detection. Any low pulse that spans at least two clock edges is therefore seen. At 125 MHz this includes a 20 ns pulse.

Top module: `wdog_strobe_monitor`

## Requirements
- R1: The period in ticks follows the select code captured at load: 0 gives 150, 1 gives 600, 2 gives 1200, and 3 also gives 1200.
- R2: A rising edge of `run_ok` loads the full selected period. Only cycles with `tick` high decrement the count. `bite` goes high in the cycle after the clock edge that samples the period-th tick since the load.
- R3: While armed, a falling edge of the synchronised strobe reloads the full period, using the select value present at that moment. The next `bite` then comes exactly one period of ticks after the strobe edge.
- R4: A rising edge of the strobe has no effect on the count.
- R5: `bite` is high for exactly one clock cycle. After it, the block stays idle with no further `bite` until `run_ok` falls and rises again.
- R6: While `run_ok` is low, the counter is idle and `bite` stays low. Strobe edges in that time are ignored.
- R7: No input disables the watchdog. Each new rise of `run_ok` with no strobe produces another `bite` after the full period.
- R8: A change of `period_sel` during a count does not alter the running count.
- R9: A strobe low pulse of 20 ns, which spans two or more clock edges at 8 ns, counts as a valid strobe.
- R10: A synchronous `rst` clears `bite` and leaves the block idle until the next rise of `run_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 1 ms count enable, one cycle wide |
| strobe | input | 1 | Asynchronous strobe from the processor; a falling edge is a keep-alive |
| period_sel | input | 2 | Timeout select code |
| run_ok | input | 1 | High while the system reset is inactive |
| bite | output | 1 | One-cycle timeout request to the reset generator |

## Verification
If the counter holds a wrong value, `bite` comes a whole number of ticks early or late. The bench counts ticks from each arm or strobe edge, so such an error shows at the first expiry, within at most 1200 ticks. If the armed flag is wrong, the result is either a second `bite` without a new rise of `run_ok`, or a missing `bite` after a release from reset. Either shows within one period. A fault in the synchroniser or edge detector shows as a reload that is missing or spurious. The next expiry then lands one strobe interval away from the expected tick.

// File: rtl/wdog_strobe_monitor.sv
module wdog_strobe_monitor #(
  parameter int unsigned SHORT_TICKS = 150,
  parameter int unsigned MID_TICKS   = 600,
  parameter int unsigned LONG_TICKS  = 1200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       strobe,
  input  logic [1:0] period_sel,
  input  logic       run_ok,
  output logic       bite
);
  localparam int unsigned MAX_AB = (SHORT_TICKS > MID_TICKS) ? SHORT_TICKS : MID_TICKS;
  localparam int unsigned MAX_T  = (MAX_AB > LONG_TICKS) ? MAX_AB : LONG_TICKS;
  localparam int CW = $clog2(MAX_T + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic          strobe_prev, run_q, armed;
  logic [CW-1:0] cnt, load_val;

  wire strobe_s = sync_q[SYNC_STAGES-1];
  wire fall     = strobe_prev & ~strobe_s;
  wire rise_ok  = run_ok & ~run_q;
  wire reload   = rise_ok | (armed & fall);
  wire expire   = armed & run_ok & ~reload & tick & (cnt == CW'(1));

  always_comb begin
    case (period_sel)
      2'd0:    load_val = CW'(SHORT_TICKS);
      2'd1:    load_val = CW'(MID_TICKS);
      default: load_val = CW'(LONG_TICKS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= '1;
      strobe_prev <= 1'b1;
      run_q       <= 1'b0;
      armed       <= 1'b0;
      cnt         <= '0;
      bite        <= 1'b0;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], strobe};
      strobe_prev <= strobe_s;
      run_q       <= run_ok;
      bite        <= expire;
      if (!run_ok) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (reload) begin
        armed <= 1'b1;
        cnt   <= load_val;
      end else if (expire) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (armed && tick) begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

module wdog_strobe_monitor_props (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic run_ok,
  input logic bite,
  input logic armed,
  input logic cnt_nz
);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst) bite |=> !bite);
  assert_idle_after_bite_R5: assert property (@(posedge clk) disable iff (rst) bite |-> !armed);
  assert_frozen_R6: assert property (@(posedge clk) disable iff (rst) !run_ok |=> (!bite && !armed));
  assert_tick_paced_R2: assert property (@(posedge clk) disable iff (rst) bite |-> $past(tick));
  assert_count_live_R1: assert property (@(posedge clk) disable iff (rst) armed |-> cnt_nz);
  assert_reset_clear_R10: assert property (@(posedge clk) rst |=> (!bite && !armed));
endmodule

bind wdog_strobe_monitor wdog_strobe_monitor_props chk (
  .clk(clk), .rst(rst), .tick(tick), .run_ok(run_ok),
  .bite(bite), .armed(armed), .cnt_nz(cnt != '0)
);

// File: tb/wdog_strobe_monitor_test.sv
`timescale 1ns/1ps
module wdog_strobe_monitor_test;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, strobe = 1'b1, run_ok = 1'b0;
  logic [1:0] period_sel = 2'd0;
  logic bite;
  int checks = 0, fails = 0;
  int tick_n = 0, bites = 0, bite_tick = 0, phase = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_strobe_monitor uut (.clk(clk), .rst(rst), .tick(tick), .strobe(strobe),
                           .period_sel(period_sel), .run_ok(run_ok), .bite(bite));

  always @(negedge clk) begin
    if (bite === 1'b1) begin bites++; bite_tick = tick_n; end
    if (phase == 7) begin tick = 1'b1; tick_n++; end else tick = 1'b0;
    phase = (phase + 1) % 8;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic align(output int ref_t);
    do @(posedge clk); while (tick !== 1'b1);
    @(negedge clk);
    ref_t = tick_n;
  endtask

  task automatic wait_ticks(int k);
    repeat (k) begin
      @(posedge clk);
      while (tick !== 1'b1) @(posedge clk);
    end
  endtask

  task automatic expect_bite(int ref_t, int n, string req);
    int base = bites;
    while (bites == base && tick_n < ref_t + n + 3) @(posedge clk);
    check(bites != base, {req, " bite seen"}, bites - base, 1);
    check(bite_tick - ref_t == n, {req, " ticks to bite"}, bite_tick - ref_t, n);
    @(negedge clk);
    check(bite === 1'b0, "R5 one-cycle pulse", bite, 0);
  endtask

  task automatic arm(logic [1:0] sel, output int ref_t);
    @(negedge clk); run_ok = 1'b0; period_sel = sel;
    repeat (3) @(negedge clk);
    align(ref_t);
    run_ok = 1'b1;
  endtask

  task automatic t_reset;
    int b;
    repeat (4) @(negedge clk);
    check(bite === 1'b0, "R10 bite low in reset", bite, 0);
    rst = 1'b0;
    b = bites;
    repeat (3) begin wait_ticks(5); @(negedge clk); strobe = 1'b0; wait_ticks(2); @(negedge clk); strobe = 1'b1; end
    check(bites == b, "R6 no bite while run_ok low", bites - b, 0);
  endtask

  task automatic t_timeout(logic [1:0] sel, int n, string req);
    int r, b;
    arm(sel, r);
    expect_bite(r, n, req);
    b = bites;
    wait_ticks(50);
    check(bites == b, "R5 idle after bite", bites - b, 0);
  endtask

  task automatic t_keepalive;
    int r, b;
    arm(2'd0, r);
    b = bites;
    repeat (5) begin
      wait_ticks(100);
      @(negedge clk); strobe = 1'b0; r = tick_n;
      repeat (3) @(negedge clk); strobe = 1'b1;
    end
    check(bites == b, "R3 strobes hold off bite", bites - b, 0);
    expect_bite(r, 150, "R3");
  endtask

  task automatic t_rise_ignored;
    int r;
    @(negedge clk); run_ok = 1'b0; strobe = 1'b0;
    repeat (3) @(negedge clk);
    period_sel = 2'd0;
    align(r); run_ok = 1'b1;
    wait_ticks(80);
    @(negedge clk); strobe = 1'b1;
    expect_bite(r, 150, "R4 R6");
  endtask

  task automatic t_freeze;
    int r, b;
    arm(2'd0, r);
    wait_ticks(100);
    @(negedge clk); run_ok = 1'b0;
    b = bites;
    wait_ticks(200);
    check(bites == b, "R6 frozen while run_ok low", bites - b, 0);
    align(r); run_ok = 1'b1;
    expect_bite(r, 150, "R2 full period after re-arm");
  endtask

  task automatic t_sel_change;
    int r;
    arm(2'd0, r);
    wait_ticks(50);
    @(negedge clk); period_sel = 2'd2;
    expect_bite(r, 150, "R8");
  endtask

  task automatic t_short_pulse;
    int r, b;
    arm(2'd0, r);
    b = bites;
    wait_ticks(120);
    align(r);
    strobe = 1'b0; #20; strobe = 1'b1;
    check(bites == b, "R9 no early bite", bites - b, 0);
    expect_bite(r, 150, "R9");
  endtask

  task automatic t_no_disable;
    int r;
    repeat (2) begin
      arm(2'd0, r);
      expect_bite(r, 150, "R7");
    end
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_timeout(2'd0, 150, "R1 sel0");
        t_timeout(2'd1, 600, "R1 sel1");
        t_timeout(2'd2, 1200, "R1 sel2");
        t_timeout(2'd3, 1200, "R1 sel3");
        t_keepalive;
        t_rise_ignored;
        t_freeze;
        t_sel_change;
        t_short_pulse;
        t_no_disable;
        done = 1;
      end
      begin
        repeat (190000) @(posedge clk);
        if (!done) begin checks++; fails++; $display("FAIL watchdog actual=%0d expected=%0d", 0, 1); end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule